// File: doc/BRIEF.md
# Mode-Selected Clock Divider Generator

This block turns one fast reference clock into three single-cycle clock-enable streams: a core enable, a peripheral enable and an external system enable. The reference clock runs at four times the notional oscillator rate, so every derived rate is a power-of-two fraction of the reference. A mode pin, captured while reset is held, picks one of two ratio schemes. In the multiplied scheme a two-bit multiplier field sets the core rate to one, two or four times the oscillator rate. The peripheral enable runs at a quarter of the core rate, and the system enable runs at the oscillator rate. In the direct scheme the multiplier field has no effect. The core and system enables then run at half the oscillator rate, and the peripheral enable runs at one eighth of it.

All three enables come from one free-running 5-bit phase counter, so they are phase-aligned. Every peripheral or system pulse lands on a core pulse. A new multiplier value is adopted only when the counter wraps, so no enable period is ever cut short. After reset is released, no enable is produced until a stabilization count, set by a 16-bit parameter, has run out.

Top module: `clkdiv_gen`

## Requirements
- R1: With STAB_CYCLES = N, all three enables stay low for the first N rising reference edges after reset release. After edge N+1, all three are high together in that cycle, which is phase zero.
- R2: In the multiplied scheme (mode latched high), the core enable pulses once per P reference cycles, counted from phase zero. P is 4 for field 2'b00, 2 for 2'b01, and 1 for 2'b10 or 2'b11.
- R3: In the multiplied scheme, the peripheral enable pulses once per 4*P reference cycles, starting at phase zero.
- R4: In the multiplied scheme, the system enable pulses once per 4 reference cycles, starting at phase zero.
- R5: In the direct scheme (mode latched low), the core enable pulses once per 8 reference cycles, whatever value the multiplier field holds or takes.
- R6: In the direct scheme, the peripheral enable pulses once per 32 reference cycles.
- R7: In the direct scheme, the system enable pulses once per 8 reference cycles and coincides with the core enable.
- R8: The mode pin is sampled on rising edges while rst_ni is low. Changes to it after release have no effect until the next reset.
- R9: A multiplier field value is adopted only at the rising edge that ends a cycle at phase 31 mod 32. Periods from the next cycle (phase 0 mod 32) follow the new value.
- R10: A peripheral or system enable is never high in a cycle where the core enable is low.
- R11: While rst_ni is low, all three enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock (4x oscillator rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_hi_i | input | 1 | Scheme select, sampled during reset: 1 multiplied, 0 direct |
| mul_sel_i | input | 2 | Core multiplier field (00 x1, 01 x2, 10/11 x4) |
| core_en_o | output | 1 | Core clock enable |
| perio_en_o | output | 1 | Peripheral clock enable |
| sys_en_o | output | 1 | External system clock enable |

## Verification
Two events can fall in the same cycle: adoption of a new multiplier value and the phase-zero pulse on all three enables. The bench provokes this by changing the multiplier field during the cycle at phase 31. It also changes the field mid-frame, both from slow to fast and from fast to slow. Each cycle, it compares every enable against a period computed from the value the bench itself expects to be active, so a change adopted early or late shows up as a missing or extra pulse. It also sweeps every field value under both schemes, and it toggles the mode pin after release.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    MUL_X1  = 2'b00,
    MUL_X2  = 2'b01,
    MUL_X4  = 2'b10,
    MUL_X4B = 2'b11
  } mul_sel_e;

  localparam int unsigned PHASE_W = 5;  // 32-cycle frame, slowest period
  localparam int unsigned LOG_W   = 3;

  // log2 of core period in reference cycles
  function automatic logic [LOG_W-1:0] core_log2(logic mode_hi, mul_sel_e sel);
    if (!mode_hi) return 3'd3;
    case (sel)
      MUL_X1:  return 3'd2;
      MUL_X2:  return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_stab.sv
module clkdiv_stab #(
  parameter int unsigned       STAB_W      = 16,
  parameter logic [STAB_W-1:0] STAB_CYCLES = 16'd1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [STAB_W-1:0] wait_q;
  logic              run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= STAB_CYCLES;
      run_q  <= 1'b0;
    end else begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      if (wait_q == '0) run_q <= 1'b1;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
#(
  parameter int unsigned CNT_W = PHASE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  mul_sel_e         mul_i,
  output logic [CNT_W-1:0] cnt_o,
  output mul_sel_e         sel_o
);
  logic [CNT_W-1:0] cnt_q;
  mul_sel_e         sel_q;
  logic             load;

  // adopt new field only at frame wrap, so no short period
  assign load = !run_i || (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= MUL_X1;
    end else begin
      if (run_i) cnt_q <= cnt_q + 1'b1;
      if (load)  sel_q <= mul_i;
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/clkdiv_tap.sv
module clkdiv_tap #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LOG_W = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LOG_W-1:0] log2_i,
  input  logic             run_i,
  output logic             en_o
);
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = ~({CNT_W{1'b1}} << log2_i);
    en_o = run_i && ((cnt_i & mask) == '0);
  end
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
#(
  parameter int unsigned       STAB_W      = 16,
  parameter logic [STAB_W-1:0] STAB_CYCLES = 16'd1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_hi_i,
  input  logic [1:0] mul_sel_i,
  output logic       core_en_o,
  output logic       perio_en_o,
  output logic       sys_en_o
);
  localparam int unsigned NUM_TAPS = 3;

  logic               mode_q;
  logic               run;
  logic [PHASE_W-1:0] phase;
  mul_sel_e           sel_act;
  logic [LOG_W-1:0]   core_lg;
  logic [LOG_W-1:0]   tap_lg [NUM_TAPS];
  logic [NUM_TAPS-1:0] tap_en;

  // mode captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= mode_hi_i;
  end

  clkdiv_stab #(
    .STAB_W      (STAB_W),
    .STAB_CYCLES (STAB_CYCLES)
  ) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  clkdiv_phase #(
    .CNT_W (PHASE_W)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mul_i  (mul_sel_e'(mul_sel_i)),
    .cnt_o  (phase),
    .sel_o  (sel_act)
  );

  always_comb begin
    core_lg   = core_log2(mode_q, sel_act);
    tap_lg[0] = core_lg;
    tap_lg[1] = core_lg + 3'd2;
    tap_lg[2] = mode_q ? 3'd2 : 3'd3;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    clkdiv_tap #(
      .CNT_W (PHASE_W),
      .LOG_W (LOG_W)
    ) u_tap (
      .cnt_i  (phase),
      .log2_i (tap_lg[g]),
      .run_i  (run),
      .en_o   (tap_en[g])
    );
  end

  assign core_en_o  = tap_en[0];
  assign perio_en_o = tap_en[1];
  assign sys_en_o   = tap_en[2];
endmodule

// File: rtl/clkdiv_gen_chk.sv
module clkdiv_gen_chk #(
  parameter int unsigned       STAB_W      = 16,
  parameter logic [STAB_W-1:0] STAB_CYCLES = 16'd1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_q,
  input logic core_en_o,
  input logic perio_en_o,
  input logic sys_en_o
);
  logic [STAB_W:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != '1) since_rst <= since_rst + 1'b1;
  end

  // R1
  stab_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst <= {1'b0, STAB_CYCLES}) |-> !(core_en_o || perio_en_o || sys_en_o));

  // R10
  perio_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perio_en_o |-> core_en_o);

  // R10
  sys_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |-> core_en_o);

  // R7
  direct_sys_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> (sys_en_o == core_en_o));

  // R5
  direct_core_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && core_en_o) |=> !core_en_o);

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != '0) |-> $stable(mode_q));
endmodule

bind clkdiv_gen clkdiv_gen_chk #(
  .STAB_W      (STAB_W),
  .STAB_CYCLES (STAB_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_q     (mode_q),
  .core_en_o  (core_en_o),
  .perio_en_o (perio_en_o),
  .sys_en_o   (sys_en_o)
);

// File: tb/clkdiv_gen_tb.sv
`timescale 1ns/1ps
module clkdiv_gen_tb;
  localparam int STAB = 12;
  localparam int NCYC = 96;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_hi_i = 1'b1;
  logic [1:0] mul_sel_i = 2'b00;
  logic       core_en_o, perio_en_o, sys_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  clkdiv_gen #(.STAB_CYCLES(16'(STAB))) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_hi_i  (mode_hi_i),
    .mul_sel_i  (mul_sel_i),
    .core_en_o  (core_en_o),
    .perio_en_o (perio_en_o),
    .sys_en_o   (sys_en_o)
  );

  // which: 0 core, 1 peripheral, 2 system
  function automatic int period(bit m, logic [1:0] s, int which);
    int pc;
    pc = m ? ((s == 2'b00) ? 4 : (s == 2'b01) ? 2 : 1) : 8;
    case (which)
      0:       return pc;
      1:       return m ? 4 * pc : 32;
      default: return m ? 4 : 8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", tag, t, act, exp);
    end
  endtask

  task automatic run_case(input bit m, input logic [1:0] s0, input logic [1:0] s1,
                          input int chg_t, input bit flip);
    logic [1:0] act_sel;
    logic [2:0] got;
    string tg [3];
    rst_ni = 1'b0;
    mode_hi_i = m;
    mul_sel_i = s0;
    repeat (3) @(negedge clk_i);
    chk("R11 core", core_en_o, 1'b0, -1);
    chk("R11 perio", perio_en_o, 1'b0, -1);
    chk("R11 sys", sys_en_o, 1'b0, -1);
    rst_ni = 1'b1;
    for (int k = 1; k <= STAB; k++) begin
      @(negedge clk_i);
      chk("R1 quiet", core_en_o | perio_en_o | sys_en_o, 1'b0, k - STAB - 1);
    end
    act_sel = s0;
    for (int t = 0; t < NCYC; t++) begin
      @(negedge clk_i);
      got = {sys_en_o, perio_en_o, core_en_o};
      tg[0] = m ? "R2 core" : "R5 core";
      tg[1] = m ? "R3 perio" : "R6 perio";
      tg[2] = m ? "R4 sys" : "R7 sys";
      if (flip) for (int w = 0; w < 3; w++) tg[w] = {"R8 ", tg[w]};
      else if (chg_t >= 0 && t > chg_t) for (int w = 0; w < 3; w++) tg[w] = {"R9 ", tg[w]};
      if (t == 0) chk("R1 first", &got, 1'b1, t);
      for (int w = 0; w < 3; w++)
        chk(tg[w], got[w], (t % period(m, act_sel, w)) == 0, t);
      chk("R10 align", (got[1] | got[2]) & ~got[0], 1'b0, t);
      if (t == chg_t) mul_sel_i = s1;
      if (flip && t == 5) mode_hi_i = ~m;
      if (t % 32 == 31) act_sel = mul_sel_i;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    for (int s = 0; s < 4; s++) run_case(1'b1, 2'(s), 2'(s), -1, 1'b0);
    for (int s = 0; s < 4; s++) run_case(1'b0, 2'(s), 2'(3 - s), 10, 1'b0);
    run_case(1'b1, 2'b00, 2'b10, 45, 1'b0);
    run_case(1'b1, 2'b10, 2'b00, 20, 1'b0);
    run_case(1'b1, 2'b01, 2'b00, 33, 1'b0);
    run_case(1'b1, 2'b00, 2'b10, 31, 1'b0);
    run_case(1'b1, 2'b01, 2'b01, -1, 1'b1);
    run_case(1'b0, 2'b10, 2'b10, -1, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule